// File: doc/BRIEF.md
# Serial Register Access Target

This block is the target side of a four-wire synchronous serial link that lets a host read and write a bank of 16-bit registers. Everything runs on the system clock. The serial clock, the active-low select and the serial input are brought in through synchronisers, and the serial clock is edge-detected, so the system clock must run at least eight times faster than the serial clock. The serial output is driven from a register in the same clock domain.

A transaction opens when the host pulls select low. It then clocks in a 16-bit command word followed by exactly one 16-bit data word, most significant bit first, with input bits sampled on rising serial-clock edges. The command decides whether the transaction is a write or a read and which of 64 registers it addresses. A write is handed to the register side as a one-cycle strobe with address and data. A read raises a one-cycle request as soon as the command is complete. The register side answers with an acknowledge and the read value, and the block shifts that value back out on falling serial-clock edges.

Top module: `sreg_slave`

## Requirements
- R1: Words are shifted in MSB first on rising `sclk` edges. Command bit 15 is the direction, where 1 means read and 0 means write. Command bits 5..0 are the register address.
- R2: Command bits 14..6 have no effect on the access that is performed or on the address that is presented.
- R3: A write transaction raises `reg_wr_en` for exactly one system-clock cycle after the 32nd rising `sclk` edge. During that cycle `reg_addr` holds the command address and `reg_wdata` holds the data word.
- R4: A read transaction raises `reg_rd_en` for exactly one system-clock cycle after the 16th rising `sclk` edge, with `reg_addr` valid. `reg_rdata` is captured in the cycle where `reg_rd_ack` is high.
- R5: On a read, the MSB of the captured value appears on `sdout` after the falling `sclk` edge that follows the 16th rising edge. Each later falling edge presents the next lower bit, so the host samples bits 15..0 on rising edges 17..32.
- R6: A select period performs at most one register access. Rising edges beyond the 32nd, and data bits clocked during a read, cause no further access.
- R7: If `cs_n` rises before the 32nd rising edge, no write strobe is issued. The bit count and shift state return to idle, so the next transaction is decoded from its first bit.
- R8: `sdout` is low while `cs_n` is high and after reset. After reset, `reg_wr_en` and `reg_rd_en` are low.
- R9: `reg_wr_en` and `reg_rd_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select from the host |
| sdin | input | 1 | Serial data from the host |
| sdout | output | 1 | Serial read data to the host |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_en | output | 1 | One-cycle register read request |
| reg_addr | output | 6 | Register address |
| reg_wdata | output | 16 | Register write data |
| reg_rd_ack | input | 1 | Read data valid from the register side |
| reg_rdata | input | 16 | Register read data |

## Verification
A pin edge reaches the frame logic after two synchroniser stages and one detection register. The strobe or request therefore appears about three system cycles after the relevant rising `sclk` edge. The `sdout` bit moves about three cycles after each falling edge. The host model holds every `sclk` level for eight system cycles and reads `sdout` in the last cycle before it raises `sclk`, which is well after the output has settled. Register-port results are checked by a monitor at each falling system-clock edge against a queue of expected accesses. An access that arrives with an empty queue, or that is still missing once select has been high for ten cycles, is reported.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 6;
  localparam int DIR_BIT = WORD_W - 1;
  localparam int FRAME_BITS = 2 * WORD_W;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              sdin_s,
  output logic              sdout,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  input  logic              reg_rd_ack,
  input  logic [WORD_W-1:0] reg_rdata
);
  localparam logic [CNT_W-1:0] CNT_CMD_LAST  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] CNT_DATA_FST  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_FRAME_LST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FRAME     = CNT_W'(FRAME_BITS);

  logic              sclk_d_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] sh_q, sh_n;
  logic [WORD_W-1:0] tx_q, tx_n;
  logic [WORD_W-1:0] wdata_q, wdata_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              is_rd_q, is_rd_n;
  logic              sdout_q, sdout_n;
  logic              wr_q, wr_n, rd_q, rd_n;
  logic              rise, fall, active;
  logic [WORD_W-1:0] word_in;

  assign rise    = sclk_s & ~sclk_d_q;
  assign fall    = ~sclk_s & sclk_d_q;
  assign active  = ~cs_n_s;
  assign word_in = {sh_q[WORD_W-2:0], sdin_s};

  always_comb begin
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    tx_n    = tx_q;
    wdata_n = wdata_q;
    addr_n  = addr_q;
    is_rd_n = is_rd_q;
    sdout_n = sdout_q;
    wr_n    = 1'b0;
    rd_n    = 1'b0;
    if (!active) begin
      cnt_n   = '0;
      sh_n    = '0;
      tx_n    = '0;
      is_rd_n = 1'b0;
      sdout_n = 1'b0;
    end else begin
      if (rise && (cnt_q < CNT_FRAME)) begin
        sh_n  = word_in;
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == CNT_CMD_LAST) begin
          is_rd_n = word_in[DIR_BIT];
          addr_n  = word_in[ADDR_W-1:0];
          rd_n    = word_in[DIR_BIT];
        end
        if ((cnt_q == CNT_FRAME_LST) && !is_rd_q) begin
          wr_n    = 1'b1;
          wdata_n = word_in;
        end
      end
      if (reg_rd_ack && is_rd_q) tx_n = reg_rdata;
      if (fall && is_rd_q && (cnt_q >= CNT_DATA_FST) && (cnt_q < CNT_FRAME)) begin
        sdout_n = tx_q[WORD_W-1];
        tx_n    = {tx_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      wdata_q  <= '0;
      addr_q   <= '0;
      is_rd_q  <= 1'b0;
      sdout_q  <= 1'b0;
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      cnt_q    <= cnt_n;
      sh_q     <= sh_n;
      tx_q     <= tx_n;
      wdata_q  <= wdata_n;
      addr_q   <= addr_n;
      is_rd_q  <= is_rd_n;
      sdout_q  <= sdout_n;
      wr_q     <= wr_n;
      rd_q     <= rd_n;
    end
  end

  assign sdout     = sdout_q;
  assign reg_wr_en = wr_q;
  assign reg_rd_en = rd_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;

  p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);
  p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !reg_rd_en);
  p_single_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == CNT_FRAME) && $stable(cnt_q)) |-> (!reg_wr_en && !reg_rd_en));
  p_idle_sdout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !sdout);
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));
endmodule

// File: rtl/sreg_slave.sv
module sreg_slave
  import sreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdin,
  output logic              sdout,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  input  logic              reg_rd_ack,
  input  logic [WORD_W-1:0] reg_rdata
);
  logic [2:0] pins_s;

  sreg_sync #(
    .W(3),
    .STAGES(SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sclk, cs_n, sdin}),
    .q    (pins_s)
  );

  sreg_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (pins_s[2]),
    .cs_n_s    (pins_s[1]),
    .sdin_s    (pins_s[0]),
    .sdout     (sdout),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rd_ack(reg_rd_ack),
    .reg_rdata (reg_rdata)
  );
endmodule

// File: tb/sreg_slave_tb.sv
module sreg_slave_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdin = 1'b0;
  logic        sdout, reg_wr_en, reg_rd_en, reg_rd_ack;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [15:0] mem [64];
  logic [21:0] wq[$];
  logic [5:0]  rq[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sreg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdin(sdin),
    .sdout(sdout), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rd_ack(reg_rd_ack), .reg_rdata(reg_rdata)
  );

  assign reg_rd_ack = reg_rd_en;
  assign reg_rdata  = mem[reg_addr];

  task automatic check(input string req, input logic [21:0] act, input logic [21:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected register accesses as the design produces them.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (reg_wr_en) begin
        if (wq.size() == 0) check("R6 unexpected write", {reg_addr, reg_wdata}, 22'h0);
        else check("R3 write addr/data", {reg_addr, reg_wdata}, wq.pop_front());
        mem[reg_addr] <= reg_wdata;
      end
      if (reg_rd_en) begin
        if (rq.size() == 0) check("R6 unexpected read", {16'h0, reg_addr}, 22'h0);
        else check("R4 read addr", {16'h0, reg_addr}, {16'h0, rq.pop_front()});
      end
      if (reg_wr_en && reg_rd_en) check("R9 exclusive", 22'h1, 22'h0);
    end
  end

  task automatic frame(input logic [15:0] cmd, input logic [15:0] dat,
                       input int nbits, output logic [15:0] got);
    cs_n = 1'b0;
    got = '0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (i < 16) sdin = cmd[15-i];
      else if (i < 32) sdin = dat[31-i];
      else sdin = i[0];
      repeat (8) @(negedge clk);
      if (i >= 16 && i < 32) got = {got[14:0], sdout};
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] d, input logic [8:0] junk);
    logic [15:0] g;
    wq.push_back({a, d});
    frame({1'b0, junk, a}, d, 32, g);
    check("R3 write delivered", {21'h0, wq.size() == 0}, 22'h1);
  endtask

  task automatic do_read(input logic [5:0] a, input logic [8:0] junk, input int nbits,
                         input logic [15:0] exp, input string req);
    logic [15:0] g;
    rq.push_back(a);
    frame({1'b1, junk, a}, 16'hFFFF, nbits, g);
    check("R4 read issued", {21'h0, rq.size() == 0}, 22'h1);
    check(req, {6'h0, g}, {6'h0, exp});
  endtask

  initial begin
    logic [15:0] g;
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h0101);
    repeat (4) @(negedge clk);
    check("R8 reset sdout", {21'h0, sdout}, 22'h0);
    check("R8 reset strobes", {20'h0, reg_wr_en, reg_rd_en}, 22'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 basic write then read back MSB first
    do_write(6'h05, 16'hA5C3, 9'h000);
    do_read(6'h05, 9'h000, 32, 16'hA5C3, "R5 read data A5C3");
    // R2 reserved bits set must not alter address or direction
    do_write(6'h2A, 16'h1234, 9'h1FF);
    do_read(6'h2A, 9'h155, 32, 16'h1234, "R2 read with reserved bits");
    // R5 pattern with MSB and LSB set
    do_write(6'h3F, 16'h8001, 9'h0AA);
    do_read(6'h3F, 9'h000, 32, 16'h8001, "R5 read data 8001");
    // R8 sdout low once select is high again after last bit 1
    check("R8 idle sdout", {21'h0, sdout}, 22'h0);
    // R6 extra clocks on a write and a read: no second access
    wq.push_back({6'h10, 16'h0F0F});
    frame({1'b0, 9'h0, 6'h10}, 16'h0F0F, 40, g);
    check("R6 write then extra clocks", {16'h0, 6'(wq.size())}, 22'h0);
    do_read(6'h10, 9'h0, 44, 16'h0F0F, "R6 read with extra clocks");
    // R7 early deselect aborts the write
    frame({1'b0, 9'h0, 6'h10}, 16'hDEAD, 24, g);
    frame({1'b0, 9'h0, 6'h10}, 16'hBEEF, 31, g);
    do_read(6'h10, 9'h0, 32, 16'h0F0F, "R7 aborted write left value");
    // R7 a short fragment then a full transaction decodes from bit 0
    frame({1'b1, 9'h1FF, 6'h3F}, 16'h0, 5, g);
    do_write(6'h01, 16'h5AA5, 9'h000);
    do_read(6'h01, 9'h000, 32, 16'h5AA5, "R7 fresh decode after fragment");
    check("R8 final idle sdout", {21'h0, sdout}, 22'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule